// File: doc/BRIEF.md
# Endpoint Handshake Response Logic

This block sits behind the packet decoder of a serial-bus device and decides how the device answers each token the host sends it. It receives the packet identifier bytes raw and checks their integrity itself. It then matches the token against the device address and the set of initialised endpoints. From the per-endpoint halt, data-ready, buffer-space and control-type flags it chooses one reply: send a data packet, ACK, NAK, STALL or stay silent. Every reply choice is reported as a one-cycle pulse, together with the identifier byte that the transmitter must send.

The block also holds the receive and transmit sequence bits of every endpoint. A received OUT data packet whose sequence bit is wrong is acknowledged but not delivered. A SETUP stage re-synchronises both bits of a control endpoint. The transmit bit advances only when the host acknowledges an IN data packet. Accepted data is reported with a strobe, so the endpoint buffer logic knows when to keep the payload. CRC checking, bit stuffing and line signalling belong to the neighbouring blocks. Those blocks report a bad CRC through a flag.

Top module: `ep_reply_engine`

## Requirements
- R1: An identifier byte is intact only when its upper nibble is the bitwise complement of its lower nibble. A token with a broken identifier byte yields reply kind NONE (0) with reply byte 0x00.
- R2: A token whose 7-bit address differs from `dev_addr` yields NONE and changes no sequence bit. The same holds for a token whose endpoint number is not below NUM_EP, or whose `ep_enable` bit is clear.
- R3: An IN token (code 1001, byte 0x69) to a matching endpoint gets a reply chosen in this priority order: STALL (kind 4, byte 0x1E) if the endpoint is halted, NAK (kind 3, byte 0x5A) if no data is ready, and otherwise DATA (kind 1) with byte 0xC3 (DATA0) or 0x4B (DATA1), picked by the transmit sequence bit.
- R4: The transmit sequence bit of an endpoint flips only when an intact ACK byte (0xD2) arrives as the first handshake after that endpoint sent data. A NAK byte, a broken byte or no handshake leaves the bit unchanged.
- R5: The data packet that follows an OUT token (code 0001, byte 0xE1) gets NONE and no accept strobe in three cases: `dat_crc_bad` is set, its identifier byte is broken, or its code is neither DATA0 (0011) nor DATA1 (1011).
- R6: An intact OUT data packet to a halted endpoint gets STALL and no accept strobe.
- R7: An intact OUT data packet whose sequence bit (bit 3 of the code) differs from the receive sequence bit gets ACK (kind 2, byte 0xD2) with no accept strobe, and the receive bit stays as it is.
- R8: An intact OUT data packet with a matching sequence bit gets ACK with an accept strobe and flips the receive bit when `ep_space` is set. When `ep_space` is clear it gets NAK, with no strobe and no flip.
- R9: The data packet of a SETUP token (code 1101, byte 0x2D) to a control endpoint is always ACKed with an accept strobe marked as setup, whatever the halt and space flags are. It then sets both sequence bits of that endpoint to 1.
- R10: A SETUP token to an endpoint that is not a control endpoint yields NONE, and the data packet after it gets no reply and no strobe. Endpoint 0 is always a control endpoint, whatever `ep_ctrl[0]` says.
- R11: A reply pulse lasts exactly one cycle. For IN and for ignored tokens it appears in the cycle after the token. For OUT and SETUP it appears in the cycle after the data packet. A new token while data is awaited abandons the wait, and a data packet with no pending OUT or SETUP is ignored. Other tokens, such as start-of-frame (0xA5), yield NONE.
- R12: Reset clears every receive and transmit sequence bit to 0 and holds `rsp_valid` and `acc_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 7 | Device address currently assigned (0 before assignment) |
| tok_valid | input | 1 | One-cycle strobe: token received |
| tok_pid | input | 8 | Raw identifier byte of the token |
| tok_addr | input | 7 | Address field of the token |
| tok_ep | input | 4 | Endpoint field of the token |
| dat_valid | input | 1 | One-cycle strobe: data packet received |
| dat_pid | input | 8 | Raw identifier byte of the data packet |
| dat_crc_bad | input | 1 | Data packet failed its CRC |
| hs_valid | input | 1 | One-cycle strobe: handshake from the host received |
| hs_pid | input | 8 | Raw identifier byte of the handshake |
| ep_enable | input | NUM_EP | Endpoint initialised |
| ep_ctrl | input | NUM_EP | Endpoint is a control endpoint (bit 0 forced) |
| ep_halt | input | NUM_EP | Endpoint halt feature set |
| ep_ready | input | NUM_EP | IN data waiting to be sent |
| ep_space | input | NUM_EP | OUT buffer can take a packet |
| rsp_valid | output | 1 | One-cycle strobe: reply chosen |
| rsp_kind | output | 3 | 0 NONE, 1 DATA, 2 ACK, 3 NAK, 4 STALL |
| rsp_pid | output | 8 | Identifier byte to transmit (0x00 for NONE) |
| acc_valid | output | 1 | One-cycle strobe: payload to be kept |
| acc_ep | output | 4 | Endpoint that keeps the payload |
| acc_setup | output | 1 | The kept payload is a setup stage |

## Verification
A wrong internal state here shows up only through later replies. A stuck or wrongly flipped transmit bit is seen at the next IN to that endpoint, as DATA0 where DATA1 is due or the other way round. A wrong receive bit is seen at the next OUT, as an ACK with no accept strobe where the payload should have been kept, or as a kept duplicate. The bench therefore runs ordered transaction sequences in which each sequence-bit change is followed at once by the transaction that exposes it. A stale wait state is seen as a missing or extra reply pulse, one cycle after the packet that should have closed it.

// File: rtl/ep_reply_pkg.sv
package ep_reply_pkg;

   localparam int ADDR_W = 7;
   localparam int EPN_W  = 4;

   localparam logic [3:0] C_OUT   = 4'b0001;
   localparam logic [3:0] C_IN    = 4'b1001;
   localparam logic [3:0] C_SOF   = 4'b0101;
   localparam logic [3:0] C_SETUP = 4'b1101;
   localparam logic [3:0] C_DATA0 = 4'b0011;
   localparam logic [3:0] C_DATA1 = 4'b1011;
   localparam logic [3:0] C_ACK   = 4'b0010;
   localparam logic [3:0] C_NAK   = 4'b1010;
   localparam logic [3:0] C_STALL = 4'b1110;
   localparam logic [3:0] C_NYET  = 4'b0110;

   typedef enum logic [2:0] {
      RK_NONE  = 3'd0,
      RK_DATA  = 3'd1,
      RK_ACK   = 3'd2,
      RK_NAK   = 3'd3,
      RK_STALL = 3'd4
   } reply_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DATA = 2'd1,
      PH_ACK  = 2'd2
   } phase_e;

   function automatic logic [7:0] wrap_code(input logic [3:0] code);
      return {~code, code};
   endfunction

   function automatic logic [7:0] reply_byte(input reply_e kind, input logic seq);
      case (kind)
         RK_DATA:  return wrap_code(seq ? C_DATA1 : C_DATA0);
         RK_ACK:   return wrap_code(C_ACK);
         RK_NAK:   return wrap_code(C_NAK);
         RK_STALL: return wrap_code(C_STALL);
         default:  return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/ep_pid_check.sv
module ep_pid_check (
   input  logic [7:0] pid_raw,
   output logic [3:0] code,
   output logic       intact
);
   assign code   = pid_raw[3:0];
   assign intact = (pid_raw[7:4] == ~pid_raw[3:0]);
endmodule

// File: rtl/ep_seq_bank.sv
module ep_seq_bank #(
   parameter int NUM_EP = 4,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              setup_set,
   input  logic              rx_flip,
   input  logic              tx_flip,
   input  logic [IDX_W-1:0]  cmd_idx,
   output logic [NUM_EP-1:0] rx_seq,
   output logic [NUM_EP-1:0] tx_seq
);
   for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
      logic sel;
      assign sel = (cmd_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rx_seq[i] <= 1'b0;
            tx_seq[i] <= 1'b0;
         end else if (sel) begin
            if (setup_set) begin
               rx_seq[i] <= 1'b1;
               tx_seq[i] <= 1'b1;
            end else begin
               if (rx_flip) rx_seq[i] <= ~rx_seq[i];
               if (tx_flip) tx_seq[i] <= ~tx_seq[i];
            end
         end
      end
   end
endmodule

// File: rtl/ep_reply_decide.sv
module ep_reply_decide
   import ep_reply_pkg::*;
#(
   parameter int NUM_EP = 4,
   parameter int IDX_W  = 2
) (
   input  phase_e            phase,
   input  logic [IDX_W-1:0]  pend_idx,
   input  logic              pend_setup,
   input  logic              tok_valid,
   input  logic [3:0]        tok_code,
   input  logic              tok_hit,
   input  logic [IDX_W-1:0]  tok_idx,
   input  logic              dat_valid,
   input  logic              dat_ok,
   input  logic              dat_seq,
   input  logic              hs_valid,
   input  logic              hs_ack,
   input  logic [NUM_EP-1:0] halt,
   input  logic [NUM_EP-1:0] ready,
   input  logic [NUM_EP-1:0] space,
   input  logic [NUM_EP-1:0] ctrl,
   input  logic [NUM_EP-1:0] rx_seq,
   input  logic [NUM_EP-1:0] tx_seq,
   output phase_e            nxt_phase,
   output logic [IDX_W-1:0]  nxt_idx,
   output logic              nxt_setup,
   output logic              fire,
   output reply_e            kind,
   output logic              seq,
   output logic              accept,
   output logic              setup_set,
   output logic              rx_flip,
   output logic              tx_flip,
   output logic [IDX_W-1:0]  cmd_idx
);
   always_comb begin
      nxt_phase = phase;
      nxt_idx   = pend_idx;
      nxt_setup = pend_setup;
      fire      = 1'b0;
      kind      = RK_NONE;
      seq       = 1'b0;
      accept    = 1'b0;
      setup_set = 1'b0;
      rx_flip   = 1'b0;
      tx_flip   = 1'b0;
      cmd_idx   = pend_idx;

      if (tok_valid) begin
         nxt_phase = PH_IDLE;
         if (!tok_hit) begin
            fire = 1'b1;
         end else if (tok_code == C_IN) begin
            fire = 1'b1;
            if (halt[tok_idx])       kind = RK_STALL;
            else if (!ready[tok_idx]) kind = RK_NAK;
            else begin
               kind      = RK_DATA;
               seq       = tx_seq[tok_idx];
               nxt_phase = PH_ACK;
               nxt_idx   = tok_idx;
            end
         end else if (tok_code == C_OUT) begin
            nxt_phase = PH_DATA;
            nxt_idx   = tok_idx;
            nxt_setup = 1'b0;
         end else if (tok_code == C_SETUP && ctrl[tok_idx]) begin
            nxt_phase = PH_DATA;
            nxt_idx   = tok_idx;
            nxt_setup = 1'b1;
         end else begin
            fire = 1'b1;
         end
      end else if (phase == PH_DATA && dat_valid) begin
         nxt_phase = PH_IDLE;
         fire      = 1'b1;
         if (!dat_ok) begin
            kind = RK_NONE;
         end else if (pend_setup) begin
            kind      = RK_ACK;
            accept    = 1'b1;
            setup_set = 1'b1;
         end else if (halt[pend_idx]) begin
            kind = RK_STALL;
         end else if (dat_seq != rx_seq[pend_idx]) begin
            kind = RK_ACK;
         end else if (space[pend_idx]) begin
            kind    = RK_ACK;
            accept  = 1'b1;
            rx_flip = 1'b1;
         end else begin
            kind = RK_NAK;
         end
      end else if (phase == PH_ACK && hs_valid) begin
         nxt_phase = PH_IDLE;
         tx_flip   = hs_ack;
      end
   end
endmodule

// File: rtl/ep_reply_engine.sv
module ep_reply_engine
   import ep_reply_pkg::*;
#(
   parameter int NUM_EP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [6:0]        dev_addr,
   input  logic              tok_valid,
   input  logic [7:0]        tok_pid,
   input  logic [6:0]        tok_addr,
   input  logic [3:0]        tok_ep,
   input  logic              dat_valid,
   input  logic [7:0]        dat_pid,
   input  logic              dat_crc_bad,
   input  logic              hs_valid,
   input  logic [7:0]        hs_pid,
   input  logic [NUM_EP-1:0] ep_enable,
   input  logic [NUM_EP-1:0] ep_ctrl,
   input  logic [NUM_EP-1:0] ep_halt,
   input  logic [NUM_EP-1:0] ep_ready,
   input  logic [NUM_EP-1:0] ep_space,
   output logic              rsp_valid,
   output logic [2:0]        rsp_kind,
   output logic [7:0]        rsp_pid,
   output logic              acc_valid,
   output logic [3:0]        acc_ep,
   output logic              acc_setup
);
   localparam int IDX_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
   localparam int N_BYTES = 3;

   if (NUM_EP < 1 || NUM_EP > 16) begin : g_bad_num_ep
      $error("ep_reply_engine: NUM_EP must lie in 1..16");
   end

   // identifier byte integrity: token, data, handshake
   logic [7:0] raw  [N_BYTES];
   logic [3:0] code [N_BYTES];
   logic       ok   [N_BYTES];
   assign raw[0] = tok_pid;
   assign raw[1] = dat_pid;
   assign raw[2] = hs_pid;

   for (genvar g = 0; g < N_BYTES; g++) begin : g_pid
      ep_pid_check u_pid (.pid_raw(raw[g]), .code(code[g]), .intact(ok[g]));
   end

   logic [IDX_W-1:0] tok_idx;
   logic             in_range, tok_hit, dat_ok, hs_ack;
   logic [NUM_EP-1:0] ctrl_eff;

   assign tok_idx  = tok_ep[IDX_W-1:0];
   assign in_range = ({1'b0, tok_ep} < 5'(NUM_EP));
   assign tok_hit  = ok[0] && (tok_addr == dev_addr) && in_range && ep_enable[tok_idx];
   assign dat_ok   = ok[1] && !dat_crc_bad && (code[1] == C_DATA0 || code[1] == C_DATA1);
   assign hs_ack   = ok[2] && (code[2] == C_ACK);

   always_comb begin
      ctrl_eff    = ep_ctrl;
      ctrl_eff[0] = 1'b1;
   end

   phase_e           phase, nxt_phase;
   logic [IDX_W-1:0] pend_idx, nxt_idx, cmd_idx;
   logic             pend_setup, nxt_setup;
   logic             fire, seq, accept, setup_set, rx_flip, tx_flip;
   reply_e           kind;
   logic [NUM_EP-1:0] rx_seq, tx_seq;

   ep_reply_decide #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_decide (
      .phase(phase), .pend_idx(pend_idx), .pend_setup(pend_setup),
      .tok_valid(tok_valid), .tok_code(code[0]), .tok_hit(tok_hit), .tok_idx(tok_idx),
      .dat_valid(dat_valid), .dat_ok(dat_ok), .dat_seq(code[1][3]),
      .hs_valid(hs_valid), .hs_ack(hs_ack),
      .halt(ep_halt), .ready(ep_ready), .space(ep_space), .ctrl(ctrl_eff),
      .rx_seq(rx_seq), .tx_seq(tx_seq),
      .nxt_phase(nxt_phase), .nxt_idx(nxt_idx), .nxt_setup(nxt_setup),
      .fire(fire), .kind(kind), .seq(seq), .accept(accept),
      .setup_set(setup_set), .rx_flip(rx_flip), .tx_flip(tx_flip), .cmd_idx(cmd_idx)
   );

   ep_seq_bank #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .setup_set(setup_set), .rx_flip(rx_flip), .tx_flip(tx_flip),
      .cmd_idx(cmd_idx), .rx_seq(rx_seq), .tx_seq(tx_seq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         pend_idx   <= '0;
         pend_setup <= 1'b0;
         rsp_valid  <= 1'b0;
         rsp_kind   <= RK_NONE;
         rsp_pid    <= 8'h00;
         acc_valid  <= 1'b0;
         acc_ep     <= 4'd0;
         acc_setup  <= 1'b0;
      end else begin
         phase      <= nxt_phase;
         pend_idx   <= nxt_idx;
         pend_setup <= nxt_setup;
         rsp_valid  <= fire;
         rsp_kind   <= fire ? kind : RK_NONE;
         rsp_pid    <= fire ? reply_byte(kind, seq) : 8'h00;
         acc_valid  <= accept;
         acc_ep     <= 4'(pend_idx);
         acc_setup  <= accept && pend_setup;
      end
   end
endmodule

// File: rtl/ep_reply_chk.sv
module ep_reply_chk #(
   parameter int NUM_EP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [6:0]        dev_addr,
   input logic              tok_valid,
   input logic [7:0]        tok_pid,
   input logic [6:0]        tok_addr,
   input logic [3:0]        tok_ep,
   input logic [NUM_EP-1:0] ep_enable,
   input logic [NUM_EP-1:0] ep_halt,
   input logic              rsp_valid,
   input logic [2:0]        rsp_kind,
   input logic              acc_valid,
   input logic              acc_setup
);
   assert_broken_token_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && (tok_pid[7:4] != ~tok_pid[3:0])) |=> (rsp_valid && rsp_kind == 3'd0));

   assert_foreign_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_addr != dev_addr) |=> (rsp_valid && rsp_kind == 3'd0));

   assert_halted_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_pid == 8'h69 && tok_addr == dev_addr && tok_ep == 4'd0
       && ep_enable[0] && ep_halt[0]) |=> (rsp_valid && rsp_kind == 3'd4));

   assert_accept_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> (rsp_valid && rsp_kind == 3'd2));

   assert_setup_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_setup |-> acc_valid);

   assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !tok_valid && !$past(tok_valid)) |=> !rsp_valid);

   assert_kind_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_kind <= 3'd4));

   assert_quiet_reset_R12: assert property (@(posedge clk)
      !rst_n |=> (!rsp_valid && !acc_valid));
endmodule

bind ep_reply_engine ep_reply_chk #(.NUM_EP(NUM_EP)) u_chk (
   .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .tok_valid(tok_valid),
   .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_ep(tok_ep),
   .ep_enable(ep_enable), .ep_halt(ep_halt), .rsp_valid(rsp_valid),
   .rsp_kind(rsp_kind), .acc_valid(acc_valid), .acc_setup(acc_setup)
);

// File: tb/sim_ep_reply_engine.sv
module sim_ep_reply_engine;
   localparam int NEP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [6:0]     dev_addr = 7'd5;
   logic           tok_valid = 1'b0, dat_valid = 1'b0, hs_valid = 1'b0, dat_crc_bad = 1'b0;
   logic [7:0]     tok_pid = 8'h00, dat_pid = 8'h00, hs_pid = 8'h00;
   logic [6:0]     tok_addr = 7'd0;
   logic [3:0]     tok_ep = 4'd0;
   logic [NEP-1:0] ep_enable = 4'b0111, ep_ctrl = 4'b0100;
   logic [NEP-1:0] ep_halt = '0, ep_ready = '0, ep_space = '0;
   logic           rsp_valid, acc_valid, acc_setup;
   logic [2:0]     rsp_kind;
   logic [7:0]     rsp_pid;
   logic [3:0]     acc_ep;

   ep_reply_engine #(.NUM_EP(NEP)) u0 (
      .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
      .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_ep(tok_ep),
      .dat_valid(dat_valid), .dat_pid(dat_pid), .dat_crc_bad(dat_crc_bad),
      .hs_valid(hs_valid), .hs_pid(hs_pid),
      .ep_enable(ep_enable), .ep_ctrl(ep_ctrl), .ep_halt(ep_halt),
      .ep_ready(ep_ready), .ep_space(ep_space),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_pid(rsp_pid),
      .acc_valid(acc_valid), .acc_ep(acc_ep), .acc_setup(acc_setup)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input bit good, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // reply monitor, sampled away from the active edge
   int         n_pulse = 0;
   logic [2:0] got_kind = 3'd7;
   logic [7:0] got_pid = 8'hFF;
   bit         got_acc = 1'b0;
   always @(negedge clk) begin
      if (rsp_valid) begin
         n_pulse++;
         got_kind = rsp_kind;
         got_pid  = rsp_pid;
      end
      if (acc_valid) got_acc = 1'b1;
   end

   // kind: 0 IN, 1 OUT, 2 SETUP, 3 SOF; ek: 0 NONE 1 DATA 2 ACK 3 NAK 4 STALL
   typedef struct packed {
      logic [1:0] kind;  logic [3:0] ep;   logic [6:0] addr; logic tbad;
      logic [7:0] dpid;  logic crc;        logic halt;       logic rdy;
      logic spc;         logic [7:0] hs;   logic [2:0] ek;   logic [7:0] epid;
      logic eacc;        logic [3:0] req;
   } row_t;

   localparam int NROWS = 27;
   localparam row_t TBL [NROWS] = '{
      '{2'd0,4'd1,7'd5,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'hD2,3'd1,8'hC3,1'b0,4'd3},  // R3 R4 DATA0, then ACK
      '{2'd0,4'd1,7'd5,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,3'd1,8'h4B,1'b0,4'd4},  // R4 flipped, no handshake
      '{2'd0,4'd1,7'd5,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'hD2,3'd1,8'h4B,1'b0,4'd4},  // R4 resend DATA1, ACK
      '{2'd0,4'd1,7'd5,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,3'd1,8'hC3,1'b0,4'd4},  // R4 back to DATA0
      '{2'd0,4'd1,7'd5,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,3'd3,8'h5A,1'b0,4'd3},  // R3 nothing ready
      '{2'd0,4'd1,7'd5,1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,8'h00,3'd4,8'h1E,1'b0,4'd3},  // R3 halt beats ready
      '{2'd0,4'd1,7'd6,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,3'd0,8'h00,1'b0,4'd2},  // R2 other address
      '{2'd0,4'd3,7'd5,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,3'd0,8'h00,1'b0,4'd2},  // R2 uninitialised ep
      '{2'd0,4'd1,7'd5,1'b1,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,3'd0,8'h00,1'b0,4'd1},  // R1 broken token
      '{2'd0,4'd2,7'd5,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h5A,3'd1,8'hC3,1'b0,4'd4},  // R4 NAK handshake
      '{2'd0,4'd2,7'd5,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'hD3,3'd1,8'hC3,1'b0,4'd4},  // R4 broken ACK byte
      '{2'd0,4'd2,7'd5,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,3'd1,8'hC3,1'b0,4'd4},  // R4 still DATA0
      '{2'd1,4'd1,7'd5,1'b0,8'hC3,1'b0,1'b0,1'b0,1'b1,8'h00,3'd2,8'hD2,1'b1,4'd8},  // R8 accept DATA0
      '{2'd1,4'd1,7'd5,1'b0,8'hC3,1'b0,1'b0,1'b0,1'b1,8'h00,3'd2,8'hD2,1'b0,4'd7},  // R7 duplicate dropped
      '{2'd1,4'd1,7'd5,1'b0,8'h4B,1'b0,1'b0,1'b0,1'b0,8'h00,3'd3,8'h5A,1'b0,4'd8},  // R8 no space
      '{2'd1,4'd1,7'd5,1'b0,8'h4B,1'b0,1'b0,1'b0,1'b1,8'h00,3'd2,8'hD2,1'b1,4'd8},  // R8 accept DATA1
      '{2'd1,4'd1,7'd5,1'b0,8'hC3,1'b1,1'b0,1'b0,1'b1,8'h00,3'd0,8'h00,1'b0,4'd5},  // R5 CRC bad
      '{2'd1,4'd1,7'd5,1'b0,8'hC2,1'b0,1'b0,1'b0,1'b1,8'h00,3'd0,8'h00,1'b0,4'd5},  // R5 broken data byte
      '{2'd1,4'd1,7'd5,1'b0,8'hD2,1'b0,1'b0,1'b0,1'b1,8'h00,3'd0,8'h00,1'b0,4'd5},  // R5 not a data code
      '{2'd1,4'd1,7'd5,1'b0,8'hC3,1'b0,1'b1,1'b0,1'b1,8'h00,3'd4,8'h1E,1'b0,4'd6},  // R6 halted
      '{2'd1,4'd1,7'd5,1'b0,8'hC3,1'b0,1'b0,1'b0,1'b1,8'h00,3'd2,8'hD2,1'b1,4'd8},  // R8 rx bit untouched by R5/R6
      '{2'd2,4'd1,7'd5,1'b0,8'hC3,1'b0,1'b0,1'b0,1'b1,8'h00,3'd0,8'h00,1'b0,4'd10}, // R10 setup non-control
      '{2'd2,4'd0,7'd5,1'b0,8'hC3,1'b0,1'b1,1'b0,1'b0,8'h00,3'd2,8'hD2,1'b1,4'd9},  // R9 R10 ep0 halted, no space
      '{2'd0,4'd0,7'd5,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,3'd1,8'h4B,1'b0,4'd9},  // R9 tx set to 1
      '{2'd1,4'd0,7'd5,1'b0,8'h4B,1'b0,1'b0,1'b0,1'b1,8'h00,3'd2,8'hD2,1'b1,4'd9},  // R9 rx set to 1
      '{2'd1,4'd0,7'd5,1'b0,8'h4B,1'b0,1'b0,1'b0,1'b1,8'h00,3'd2,8'hD2,1'b0,4'd7},  // R7 rx flipped to 0
      '{2'd3,4'd0,7'd5,1'b0,8'h00,1'b0,1'b0,1'b1,1'b1,8'h00,3'd0,8'h00,1'b0,4'd11}  // R11 start-of-frame
   };

   task automatic clear_mon();
      n_pulse = 0; got_kind = 3'd7; got_pid = 8'hFF; got_acc = 1'b0;
   endtask

   task automatic send_tok(input logic [1:0] kind, input logic [3:0] ep,
                           input logic [6:0] addr, input logic bad);
      logic [7:0] b;
      case (kind)
         2'd0: b = 8'h69;
         2'd1: b = 8'hE1;
         2'd2: b = 8'h2D;
         default: b = 8'hA5;
      endcase
      @(negedge clk);
      tok_valid = 1'b1; tok_pid = bad ? (b ^ 8'h80) : b; tok_addr = addr; tok_ep = ep;
      @(negedge clk);
      tok_valid = 1'b0;
   endtask

   task automatic send_dat(input logic [7:0] p, input logic crc);
      @(negedge clk);
      dat_valid = 1'b1; dat_pid = p; dat_crc_bad = crc;
      @(negedge clk);
      dat_valid = 1'b0; dat_crc_bad = 1'b0;
   endtask

   task automatic send_hs(input logic [7:0] p);
      @(negedge clk);
      hs_valid = 1'b1; hs_pid = p;
      @(negedge clk);
      hs_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic run_row(input row_t r);
      string tag;
      tag = $sformatf("R%0d", r.req);
      ep_halt = {NEP{r.halt}}; ep_ready = {NEP{r.rdy}}; ep_space = {NEP{r.spc}};
      clear_mon();
      send_tok(r.kind, r.ep, r.addr, r.tbad);
      if (r.kind == 2'd1 || r.kind == 2'd2) send_dat(r.dpid, r.crc);
      if (r.kind == 2'd0 && r.hs != 8'h00) send_hs(r.hs);
      idle(3);
      chk(n_pulse == 1, tag, "pulse count", n_pulse, 1);
      chk(got_kind == r.ek, tag, "reply kind", int'(got_kind), int'(r.ek));
      chk(got_pid == r.epid, tag, "reply byte", int'(got_pid), int'(r.epid));
      chk(got_acc == r.eacc, tag, "accept strobe", int'(got_acc), int'(r.eacc));
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R12: quiet during reset
      idle(4);
      chk(rsp_valid == 1'b0, "R12", "rsp_valid in reset", int'(rsp_valid), 0);
      chk(acc_valid == 1'b0, "R12", "acc_valid in reset", int'(acc_valid), 0);
      rst_n = 1'b1;
      idle(2);

      for (int i = 0; i < NROWS; i++) run_row(TBL[i]);

      // R11: reply in the cycle after the token, one cycle wide
      ep_halt = '0; ep_ready = '1; ep_space = '1;
      @(negedge clk);
      tok_valid = 1'b1; tok_pid = 8'h69; tok_addr = 7'd5; tok_ep = 4'd1;
      @(negedge clk);
      tok_valid = 1'b0;
      chk(rsp_valid == 1'b1, "R11", "reply one cycle after token", int'(rsp_valid), 1);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R11", "reply lasts one cycle", int'(rsp_valid), 0);
      idle(2);

      // R11: new token abandons a pending OUT; a stray data packet is ignored
      clear_mon();
      send_tok(2'd1, 4'd1, 7'd5, 1'b0);
      send_tok(2'd0, 4'd2, 7'd5, 1'b0);
      idle(2);
      chk(got_kind == 3'd1 && got_pid == 8'hC3, "R11", "IN after abandoned OUT",
          int'(got_pid), 8'hC3);
      send_dat(8'hC3, 1'b0);
      idle(3);
      chk(n_pulse == 1, "R11", "stray data ignored", n_pulse, 1);
      chk(got_acc == 1'b0, "R11", "stray data not kept", int'(got_acc), 0);

      // R12: reset clears the ep0 transmit bit left at 1 by the setup stage
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
      clear_mon();
      send_tok(2'd0, 4'd0, 7'd5, 1'b0);
      idle(2);
      chk(got_pid == 8'hC3, "R12", "tx bit after reset", int'(got_pid), 8'hC3);
      // R12: receive bit of ep1 back to 0 after reset
      clear_mon();
      send_tok(2'd1, 4'd1, 7'd5, 1'b0);
      send_dat(8'hC3, 1'b0);
      idle(3);
      chk(got_acc == 1'b1, "R12", "rx bit after reset", int'(got_acc), 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule